// File: doc/BRIEF.md
# UART Receive Character Queue

This block is the receive-side character store of a memory-mapped UART. Each entry carries an 8-bit character, three line-error flags and a break marker. Entries arrive from the serial deserializer, from the transmit-side loopback path or as a break event. They leave one at a time when the processor reads the data register. The block drives the empty and full flags, a space-available count for the deserializer and a receive-level interrupt request. It also latches the error and break flags of the character just read into a status register.

The same storage runs in two modes, chosen by the FIFO-enable bit of the line control register. With the bit set, the queue holds 16 entries. With it clear, the queue is a single holding register. Both modes use one index calculation masked by the effective depth, so a change of mode only changes the mask and empties the queue.

Top module: `rxq_top`

## Requirements
- R1: After reset the queue is empty (empty 1, full 0), the interrupt is low, the status is 0, the mode is single-entry (space 1) and the level register reads 0x12.
- R2: In FIFO mode up to 16 entries are held and returned in arrival order. Full rises when the count reaches 16. space_o always equals the effective depth minus the count.
- R3: A push while the count equals the effective depth is dropped, and the queue contents do not change.
- R4: In single-entry mode one push fills the queue (full 1, space 0), and a second push is dropped.
- R5: The interrupt rises when a push makes the count exactly equal to the trigger level.
- R6: The interrupt falls when a read leaves a count that is one below the trigger level.
- R7: A read of an empty queue leaves the count at zero and empty at 1, and clears full.
- R8: A read copies the popped entry's flags into status as {brk, err[2:0]}. Any status write clears it to 0.
- R9: A change of fifo_en_i empties the queue (count 0, empty 1, full 0) at the next edge. Pushes and reads in that cycle are ignored.
- R10: While loopback is enabled, deserializer characters and break events are ignored and loopback characters are queued. While it is disabled, loopback characters are ignored.
- R11: A break event queues the entry 0x800 (brk bit 11 set, char and errors 0). It takes priority over a deserializer character in the same cycle.
- R12: A level-register write stores the value. The trigger level stays at 1 after reset and after any line-control or level write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en_i | input | 1 | Line-control FIFO-enable bit (1 = 16 entries) |
| lc_wr_i | input | 1 | Line-control register write strobe |
| lvl_wr_i | input | 1 | Level register write strobe |
| lvl_wdata_i | input | 6 | Level register write value |
| lvl_o | output | 6 | Level register contents |
| lb_en_i | input | 1 | Loopback enable |
| ds_valid_i | input | 1 | Deserializer character valid |
| ds_char_i | input | 8 | Deserializer character |
| ds_err_i | input | 3 | Deserializer error flags |
| brk_evt_i | input | 1 | Break detected on the line |
| lb_valid_i | input | 1 | Loopback character valid |
| lb_char_i | input | 8 | Loopback character |
| rd_i | input | 1 | Data register read strobe |
| rd_data_o | output | 12 | Head entry {brk, err[2:0], char[7:0]} |
| stat_wr_i | input | 1 | Status register write strobe |
| stat_o | output | 4 | Latched status {brk, err[2:0]} |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full |
| space_o | output | 5 | Free entries |
| rx_irq_o | output | 1 | Receive-level interrupt request |

## Verification
The assertions assume that rst_n is low at the first edge and that the deserializer honours space_o, although a push into a full queue must still be dropped. The stimulus changes inputs shortly after a rising edge and holds each strobe for exactly one cycle. It never combines a mode change with a push or read it expects to take effect. Overflow pushes and reads of an empty queue are applied on purpose, so the drop paths are exercised inside these limits.

// File: rtl/rxq_pkg.sv
// Shared entry layout for the receive character queue.
// Assumes the character is 8 bits with three error flags and one break bit.
package rxq_pkg;
    localparam int CHAR_W = 8;
    localparam int ERR_W  = 3;
    localparam int ENT_W  = CHAR_W + ERR_W + 1;
    localparam int STAT_W = ERR_W + 1;

    typedef struct packed {
        logic              brk;
        logic [ERR_W-1:0]  err;
        logic [CHAR_W-1:0] ch;
    } rxq_ent_t;
endpackage

// File: rtl/rxq_store.sv
// Storage, read index and occupancy of the receive queue.
// Effective depth is DEPTH when mode_q is 1 and 1 otherwise. Slot indices are
// masked by depth-1, so DEPTH must be a power of two of at least 2.
// A change of mode_i flushes the queue and blocks that cycle's push and read.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_i,
    input  logic          push_i,
    input  rxq_ent_t      push_ent_i,
    input  logic          rd_i,
    output rxq_ent_t      rd_ent_o,
    output logic          push_ok_o,
    output logic          rd_ok_o,
    output logic [CW-1:0] cnt_rd_o,
    output logic [CW-1:0] cnt_nxt_o,
    output logic [CW-1:0] space_o,
    output logic          full_o,
    output logic          empty_o
);
    localparam logic [CW-1:0] ONE    = CW'(1);
    localparam logic [CW-1:0] DEP_W  = CW'(DEPTH);
    localparam logic [AW-1:0] MASK_F = AW'(DEPTH - 1);

    logic          mode_q;
    logic [AW-1:0] pos_q;
    logic [CW-1:0] cnt_q;
    logic          full_q, empty_q;
    rxq_ent_t      mem_q [DEPTH];

    logic          flush;
    logic [CW-1:0] depth;
    logic [AW-1:0] mask, wr_slot;

    // Decode the effective depth and the per-cycle push and read permission.
    always_comb begin
        flush     = (mode_i != mode_q);
        depth     = mode_q ? DEP_W : ONE;
        mask      = mode_q ? MASK_F : '0;
        wr_slot   = (pos_q + cnt_q[AW-1:0]) & mask;
        push_ok_o = push_i && !flush && (cnt_q < depth);
        rd_ok_o   = rd_i && !flush;
        cnt_rd_o  = (rd_ok_o && cnt_q != '0) ? cnt_q - ONE : cnt_q;
        cnt_nxt_o = cnt_rd_o + (push_ok_o ? ONE : '0);
        space_o   = depth - cnt_q;
    end

    assign rd_ent_o = mem_q[pos_q];
    assign full_o   = full_q;
    assign empty_o  = empty_q;

    // Track the mode, read index, count and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= 1'b0;
            pos_q   <= '0;
            cnt_q   <= '0;
            full_q  <= 1'b0;
            empty_q <= 1'b1;
        end else if (flush) begin
            mode_q  <= mode_i;
            pos_q   <= '0;
            cnt_q   <= '0;
            full_q  <= 1'b0;
            empty_q <= 1'b1;
        end else begin
            cnt_q <= cnt_nxt_o;
            if (rd_ok_o && cnt_q != '0)
                pos_q <= (pos_q + AW'(1)) & mask;
            if (rd_ok_o)
                full_q <= 1'b0;
            if (rd_ok_o && cnt_rd_o == '0)
                empty_q <= 1'b1;
            if (push_ok_o)
                empty_q <= 1'b0;
            if (push_ok_o && cnt_nxt_o == depth)
                full_q <= 1'b1;
        end
    end

    // Write accepted entries into the storage slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= '0;
        end else if (push_ok_o) begin
            mem_q[wr_slot] <= push_ent_i;
        end
    end

    // R2
    no_full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_q && empty_q));
    // R2
    full_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_q |-> (cnt_q == depth));
    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= depth);
    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt_q == '0 && empty_q && !full_q));
    // R7
    empty_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok_o && cnt_q == '0 && !push_ok_o) |=> (cnt_q == '0 && empty_q && !full_q));
endmodule

// File: rtl/rxq_irq.sv
// Level register, trigger level and the receive-level interrupt request.
// The trigger returns to TRIG_INIT on reset and on any line-control or level
// write. The interrupt is set and cleared only on exact count matches.
module rxq_irq #(
    parameter int CW = 5,
    parameter int LVL_W = 6,
    parameter logic [LVL_W-1:0] LVL_RST = 6'h12,
    parameter int TRIG_INIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lc_wr_i,
    input  logic             lvl_wr_i,
    input  logic [LVL_W-1:0] lvl_wdata_i,
    input  logic             push_ok_i,
    input  logic             rd_ok_i,
    input  logic [CW-1:0]    cnt_rd_i,
    input  logic [CW-1:0]    cnt_nxt_i,
    output logic [LVL_W-1:0] lvl_o,
    output logic             irq_o
);
    localparam logic [CW-1:0] TRIG_W = CW'(TRIG_INIT);

    logic [CW-1:0]    trig_q;
    logic [LVL_W-1:0] lvl_q;
    logic             irq_q;

    assign lvl_o = lvl_q;
    assign irq_o = irq_q;

    // Hold the level register and force the trigger back on configuration writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= LVL_RST;
            trig_q <= TRIG_W;
        end else begin
            if (lvl_wr_i)
                lvl_q <= lvl_wdata_i;
            if (lvl_wr_i || lc_wr_i)
                trig_q <= TRIG_W;
        end
    end

    // Clear on a read that drops below the trigger, set on a push that reaches it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            if (rd_ok_i && (cnt_rd_i + CW'(1)) == trig_q)
                irq_q <= 1'b0;
            if (push_ok_i && cnt_nxt_i == trig_q)
                irq_q <= 1'b1;
        end
    end

    // R5
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok_i && cnt_nxt_i == trig_q) |=> irq_q);
    // R6
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok_i && (cnt_rd_i + CW'(1)) == trig_q && !push_ok_i) |=> !irq_q);
    // R12
    trig_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_wr_i || lc_wr_i) |=> (trig_q == TRIG_W));
endmodule

// File: rtl/rxq_status.sv
// Receive status latch: captures the flags of each popped entry.
// A status write takes priority over a read in the same cycle.
module rxq_status
    import rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_ok_i,
    input  rxq_ent_t          rd_ent_i,
    input  logic              wr_i,
    output logic [STAT_W-1:0] stat_o
);
    // Latch {brk, err} on a read and clear on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_o <= '0;
        else if (wr_i)
            stat_o <= '0;
        else if (rd_ok_i)
            stat_o <= {rd_ent_i.brk, rd_ent_i.err};
    end

    // R8
    stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (stat_o == '0));
endmodule

// File: rtl/rxq_top.sv
// Receive character queue of a UART.
// Selects one source per cycle (break, then loopback or deserializer) and
// connects the storage, the interrupt logic and the status latch.
// Assumes that at most one read strobe arrives per cycle.
module rxq_top
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = 6,
    parameter logic [LVL_W-1:0] LVL_RST = 6'h12,
    parameter int TRIG_INIT = 1,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en_i,
    input  logic              lc_wr_i,
    input  logic              lvl_wr_i,
    input  logic [LVL_W-1:0]  lvl_wdata_i,
    output logic [LVL_W-1:0]  lvl_o,
    input  logic              lb_en_i,
    input  logic              ds_valid_i,
    input  logic [CHAR_W-1:0] ds_char_i,
    input  logic [ERR_W-1:0]  ds_err_i,
    input  logic              brk_evt_i,
    input  logic              lb_valid_i,
    input  logic [CHAR_W-1:0] lb_char_i,
    input  logic              rd_i,
    output logic [ENT_W-1:0]  rd_data_o,
    input  logic              stat_wr_i,
    output logic [STAT_W-1:0] stat_o,
    output logic              empty_o,
    output logic              full_o,
    output logic [CW-1:0]     space_o,
    output logic              rx_irq_o
);
    rxq_ent_t      push_ent, rd_ent;
    logic          push, push_ok, rd_ok;
    logic [CW-1:0] cnt_rd, cnt_nxt;

    // Pick the entry offered this cycle.
    always_comb begin
        push     = 1'b0;
        push_ent = '0;
        if (brk_evt_i && !lb_en_i) begin
            push         = 1'b1;
            push_ent.brk = 1'b1;
        end else if (lb_en_i && lb_valid_i) begin
            push        = 1'b1;
            push_ent.ch = lb_char_i;
        end else if (!lb_en_i && ds_valid_i) begin
            push         = 1'b1;
            push_ent.ch  = ds_char_i;
            push_ent.err = ds_err_i;
        end
    end

    rxq_store #(.DEPTH(DEPTH)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (fifo_en_i),
        .push_i     (push),
        .push_ent_i (push_ent),
        .rd_i       (rd_i),
        .rd_ent_o   (rd_ent),
        .push_ok_o  (push_ok),
        .rd_ok_o    (rd_ok),
        .cnt_rd_o   (cnt_rd),
        .cnt_nxt_o  (cnt_nxt),
        .space_o    (space_o),
        .full_o     (full_o),
        .empty_o    (empty_o)
    );

    rxq_irq #(
        .CW        (CW),
        .LVL_W     (LVL_W),
        .LVL_RST   (LVL_RST),
        .TRIG_INIT (TRIG_INIT)
    ) irq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .lc_wr_i     (lc_wr_i),
        .lvl_wr_i    (lvl_wr_i),
        .lvl_wdata_i (lvl_wdata_i),
        .push_ok_i   (push_ok),
        .rd_ok_i     (rd_ok),
        .cnt_rd_i    (cnt_rd),
        .cnt_nxt_i   (cnt_nxt),
        .lvl_o       (lvl_o),
        .irq_o       (rx_irq_o)
    );

    rxq_status status_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_ok_i  (rd_ok),
        .rd_ent_i (rd_ent),
        .wr_i     (stat_wr_i),
        .stat_o   (stat_o)
    );

    assign rd_data_o = rd_ent;

    // R10
    lb_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_en_i && !lb_valid_i) |-> !push);
endmodule

// File: tb/rxq_top_tb_top.sv
// Scoreboard bench: driver tasks queue expected entries, a monitor compares reads.
module rxq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en_i = 1'b0, lc_wr_i = 1'b0, lvl_wr_i = 1'b0;
    logic [5:0]  lvl_wdata_i = '0, lvl_o;
    logic        lb_en_i = 1'b0, ds_valid_i = 1'b0, brk_evt_i = 1'b0, lb_valid_i = 1'b0;
    logic [7:0]  ds_char_i = '0, lb_char_i = '0;
    logic [2:0]  ds_err_i = '0;
    logic        rd_i = 1'b0, stat_wr_i = 1'b0;
    logic [11:0] rd_data_o;
    logic [3:0]  stat_o;
    logic        empty_o, full_o, rx_irq_o;
    logic [4:0]  space_o;

    int          checks = 0, fails = 0;
    bit          done = 0;
    bit          mode_m = 0, lb_m = 0;
    logic [11:0] exp_q [$];
    string       mon_tag = "R2";

    always #10 clk = ~clk;

    rxq_top dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_en_i(fifo_en_i), .lc_wr_i(lc_wr_i),
        .lvl_wr_i(lvl_wr_i), .lvl_wdata_i(lvl_wdata_i), .lvl_o(lvl_o),
        .lb_en_i(lb_en_i), .ds_valid_i(ds_valid_i), .ds_char_i(ds_char_i),
        .ds_err_i(ds_err_i), .brk_evt_i(brk_evt_i), .lb_valid_i(lb_valid_i),
        .lb_char_i(lb_char_i), .rd_i(rd_i), .rd_data_o(rd_data_o),
        .stat_wr_i(stat_wr_i), .stat_o(stat_o), .empty_o(empty_o),
        .full_o(full_o), .space_o(space_o), .rx_irq_o(rx_irq_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Offer one entry: src 0 deserializer, 1 loopback, 2 break.
    task automatic push(input int src, input logic [7:0] ch, input logic [2:0] er);
        logic [11:0] ent;
        bit acc;
        int dep;
        dep = mode_m ? 16 : 1;
        if (src == 0) begin ent = {1'b0, er, ch}; acc = !lb_m; end
        else if (src == 1) begin ent = {4'b0, ch}; acc = lb_m; end
        else begin ent = 12'h800; acc = !lb_m; end
        if (acc && exp_q.size() < dep) exp_q.push_back(ent);
        @(posedge clk); #1;
        ds_valid_i = (src == 0); ds_char_i = ch; ds_err_i = er;
        lb_valid_i = (src == 1); lb_char_i = ch;
        brk_evt_i  = (src == 2);
        @(posedge clk); #1;
        ds_valid_i = 0; lb_valid_i = 0; brk_evt_i = 0;
    endtask

    task automatic rd();
        @(posedge clk); #1; rd_i = 1;
        @(posedge clk); #1; rd_i = 0;
    endtask

    task automatic set_mode(input bit m);
        @(posedge clk); #1; fifo_en_i = m;
        @(posedge clk); #1;
        mode_m = m;
        exp_q.delete();
    endtask

    task automatic pulse_stat_wr();
        @(posedge clk); #1; stat_wr_i = 1;
        @(posedge clk); #1; stat_wr_i = 0;
    endtask

    // Monitor: compare each read against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && rd_i && exp_q.size() > 0) begin
            logic [11:0] e;
            e = exp_q.pop_front();
            chk(rd_data_o == e, mon_tag, rd_data_o, e);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1;
        // R1 reset state
        chk(empty_o == 1 && full_o == 0, "R1 flags", {empty_o, full_o}, 2'b10);
        chk(rx_irq_o == 0 && stat_o == 0, "R1 irq/stat", {rx_irq_o, stat_o}, 0);
        chk(space_o == 1, "R1 space", space_o, 1);
        chk(lvl_o == 6'h12, "R1 level", lvl_o, 6'h12);

        // R4 single-entry mode, R5 interrupt rise
        mon_tag = "R4 single";
        push(0, 8'h41, 3'b000);
        chk(full_o == 1 && space_o == 0, "R4 full", {full_o, space_o}, 6'h20);
        chk(rx_irq_o == 1, "R5 irq set", rx_irq_o, 1);
        push(0, 8'h42, 3'b000);                       // R3 dropped
        chk(space_o == 0, "R3 single drop", space_o, 0);
        rd();
        chk(empty_o == 1 && rx_irq_o == 0, "R6 irq drop", {empty_o, rx_irq_o}, 2'b10);

        // R7 read of empty queue
        rd();
        chk(empty_o == 1 && full_o == 0 && space_o == 1, "R7 empty read",
            {empty_o, full_o, space_o}, {1'b1, 1'b0, 5'd1});

        // R9 mode switch to FIFO
        set_mode(1);
        chk(space_o == 16, "R9 depth 16", space_o, 16);

        // R2 fill, R3 overflow, order
        mon_tag = "R2 order";
        for (int i = 0; i < 16; i++) push(0, 8'h30 + 8'(i), 3'(i));
        chk(full_o == 1 && space_o == 0, "R2 full", {full_o, space_o}, 6'h20);
        push(0, 8'hEE, 3'b111);                       // R3 dropped
        chk(full_o == 1 && space_o == 0, "R3 overflow", {full_o, space_o}, 6'h20);
        rd();
        chk(full_o == 0 && space_o == 1, "R2 space after read", {full_o, space_o}, 6'h01);
        for (int i = 0; i < 15; i++) rd();
        chk(empty_o == 1 && rx_irq_o == 0, "R6 drained", {empty_o, rx_irq_o}, 2'b10);

        // R8 status latch and clear
        mon_tag = "R8 data";
        push(0, 8'h55, 3'b101);
        rd();
        chk(stat_o == 4'b0101, "R8 latch", stat_o, 4'b0101);
        pulse_stat_wr();
        chk(stat_o == 0, "R8 clear", stat_o, 0);

        // R11 break with simultaneous character
        mon_tag = "R11 break";
        exp_q.push_back(12'h800);
        @(posedge clk); #1; brk_evt_i = 1; ds_valid_i = 1; ds_char_i = 8'h77;
        @(posedge clk); #1; brk_evt_i = 0; ds_valid_i = 0;
        chk(space_o == 15, "R11 one entry", space_o, 15);
        rd();
        chk(stat_o == 4'b1000, "R11 status", stat_o, 4'b1000);

        // R10 loopback
        mon_tag = "R10 loopback";
        @(posedge clk); #1; lb_en_i = 1; lb_m = 1;
        push(0, 8'h11, 3'b001);
        push(2, 8'h00, 3'b000);
        chk(empty_o == 1 && space_o == 16, "R10 rx ignored", {empty_o, space_o}, {1'b1, 5'd16});
        push(1, 8'hA5, 3'b000);
        chk(space_o == 15, "R10 lb queued", space_o, 15);
        rd();
        @(posedge clk); #1; lb_en_i = 0; lb_m = 0;
        push(1, 8'h5A, 3'b000);
        chk(empty_o == 1, "R10 lb ignored", empty_o, 1);

        // R9 flush with content
        push(0, 8'h01, 3'b000);
        push(0, 8'h02, 3'b000);
        push(0, 8'h03, 3'b000);
        set_mode(0);
        chk(empty_o == 1 && full_o == 0 && space_o == 1, "R9 flush",
            {empty_o, full_o, space_o}, {1'b1, 1'b0, 5'd1});
        set_mode(1);

        // R12 level write, trigger stays 1
        @(posedge clk); #1; lvl_wr_i = 1; lvl_wdata_i = 6'h05;
        @(posedge clk); #1; lvl_wr_i = 0; lc_wr_i = 1;
        @(posedge clk); #1; lc_wr_i = 0;
        chk(lvl_o == 6'h05, "R12 level", lvl_o, 6'h05);
        rd();                                        // empty read resets irq state
        mon_tag = "R12 data";
        push(0, 8'h66, 3'b000);
        chk(rx_irq_o == 1, "R12 trigger one", rx_irq_o, 1);
        push(0, 8'h67, 3'b000);
        rd();
        chk(rx_irq_o == 1, "R6 no drop above trigger", rx_irq_o, 1);
        rd();
        chk(rx_irq_o == 0, "R6 drop at empty", rx_irq_o, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule